// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timer with Short-Pulse Suppression

This block drives three inverter legs from one triangular time base. Each leg has a high-side and a low-side output. An up/down counter runs from zero to the programmed period count P and back again. Every output pulse is therefore symmetric about either the period midpoint (high side) or the period boundary (low side). The high-side on-time in each half period is the leg's duty count less the dead-time count. The low-side on-time is P less the duty count less the dead-time count. Both results saturate at zero. A minimum pulse width guards the power switches. When either on-time in a half falls below the programmed minimum, that output is dropped for the whole half and its partner is held fully on.

The period, the duty counts, the dead time, the minimum width and the update mode are captured into shadow registers once per period. In the twice-per-period mode, the duty counts are also captured at the midpoint, which gives one-count resolution over the full period. A one-cycle strobe marks the first cycle of every period, so software or a sampling unit can align to it. All outputs are registered.

Top module: `pwm3_timer`

## Requirements
- R1: While rst_ni is low, hi_o, lo_o and sync_o are 0. After rst_ni rises at a clock edge, the outputs stay 0 for one more cycle and sync_o is high in the second cycle.
- R2: sync_o is high for exactly one cycle at the start of every period. With captured period count P (P ≥ 1), successive sync_o cycles are 2·P cycles apart. The first P cycles from the sync_o cycle form the first half and the next P form the second half.
- R3: For leg k, the duty count is duty_i[k*CNT_W +: CNT_W] and drives hi_o[k]; leg A is k=0, B is 1, C is 2. Unless suppressed, hi_o[k] is high for max(duty−dead,0) cycles per half (capped at P). The pulse ends at the last cycle of the first half and starts at the first cycle of the second half.
- R4: Unless suppressed, lo_o[k] is high for max(P−duty−dead,0) cycles per half. The pulse starts at the sync_o cycle in the first half and ends at the last cycle of the second half.
- R5: Within one period, counted from its sync_o cycle, each hi_o bit rises at most once and each lo_o bit falls at most once.
- R6: If the high-side on-time of a half is below min_width_i, hi_o[k] is 0 and lo_o[k] is 1 for that whole half. Example: P=200, duty 5, dead 3, minimum 10.
- R7: If the low-side on-time of a half is below min_width_i, lo_o[k] is 0 and hi_o[k] is 1 for that whole half.
- R8: If both on-times of a half are below the minimum, both outputs of that leg are 0 for the half. hi_o[k] and lo_o[k] are never high together.
- R9: With dbl_update_i = 0 in force, input changes made after a period's capture edge have no effect until the next period.
- R10: With dbl_update_i = 1 in force, the duty counts are captured again at the midpoint and apply to the second half. The period, dead-time and minimum inputs are captured only at period start.
- R11: A change of dbl_update_i takes effect only from the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Half-period count P |
| duty_i | input | NUM_LEGS*CNT_W | Duty counts, leg k in bits [k*CNT_W +: CNT_W] |
| dead_i | input | CNT_W | Dead-time count |
| min_width_i | input | CNT_W | Minimum on-time per half, in cycles |
| dbl_update_i | input | 1 | 0: capture once per period, 1: also at midpoint |
| sync_o | output | 1 | High in the first cycle of each period |
| hi_o | output | NUM_LEGS | High-side outputs, active high |
| lo_o | output | NUM_LEGS | Low-side outputs, active high |

## Verification
The bench builds the block with CNT_W = 10 and NUM_LEGS = 3. These widths keep short periods of 10 to 16 counts cheap to step through, while still fitting the 200-count suppression case in full. Three legs can be programmed at the same time into distinct regimes: normal, high side suppressed, and low side suppressed or clamped. A single period therefore covers both saturation paths and both forcing directions. Changing inputs in the sync cycle separates the midpoint capture from the period-start capture.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  typedef enum logic {
    UPD_ONCE  = 1'b0,
    UPD_TWICE = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/pwm3_counter.sv
module pwm3_counter
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] per_i,
  input  upd_mode_e        mode_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             run_o,
  output logic             start_o,
  output logic             full_ld_o,
  output logic             half_ld_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic             run_q;
  logic [CNT_W:0]   nxt_up;
  logic             turn;

  assign nxt_up    = {1'b0, cnt_q} + 1'b1;
  assign turn      = up_q && (nxt_up >= {1'b0, per_i});
  assign full_ld_o = !up_q && (cnt_q <= CNT_W'(1));
  assign half_ld_o = turn && (mode_i == UPD_TWICE);
  // Both halves map onto positions 0..P-1, the second one in reverse
  assign pos_o     = up_q ? cnt_q : cnt_q - 1'b1;
  assign run_o     = run_q;
  assign start_o   = run_q && up_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (full_ld_o) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      run_q <= 1'b1;
    end else if (up_q) begin
      cnt_q <= nxt_up[CNT_W-1:0];
      if (turn) up_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pwm3_shadow.sv
module pwm3_shadow
  import pwm3_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int NUM_LEGS = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      full_ld_i,
  input  logic                      half_ld_i,
  input  logic [CNT_W-1:0]          per_i,
  input  logic [NUM_LEGS*CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0]          dead_i,
  input  logic [CNT_W-1:0]          minw_i,
  input  logic                      mode_i,
  output logic [CNT_W-1:0]          per_o,
  output logic [NUM_LEGS*CNT_W-1:0] duty_o,
  output logic [CNT_W-1:0]          dead_o,
  output logic [CNT_W-1:0]          minw_o,
  output upd_mode_e                 mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o  <= '0;
      duty_o <= '0;
      dead_o <= '0;
      minw_o <= '0;
      mode_o <= UPD_ONCE;
    end else if (full_ld_i) begin
      per_o  <= per_i;
      duty_o <= duty_i;
      dead_o <= dead_i;
      minw_o <= minw_i;
      mode_o <= upd_mode_e'(mode_i);
    end else if (half_ld_i) begin
      duty_o <= duty_i;
    end
  end
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] pos_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] minw_i,
  output logic             hi_o,
  output logic             lo_o
);
  logic [CNT_W:0]   dsum, on_hi, on_lo;
  logic [CNT_W+1:0] hi_reach;
  logic             short_hi, short_lo, hi_win, lo_win;

  assign dsum     = {1'b0, duty_i} + {1'b0, dead_i};
  assign on_hi    = (duty_i > dead_i) ? {1'b0, duty_i - dead_i} : '0;
  assign on_lo    = ({1'b0, per_i} > dsum) ? {1'b0, per_i} - dsum : '0;
  assign short_hi = on_hi < {1'b0, minw_i};
  assign short_lo = on_lo < {1'b0, minw_i};
  assign hi_reach = {2'b0, pos_i} + {1'b0, on_hi};
  assign hi_win   = hi_reach >= {2'b0, per_i};
  assign lo_win   = {1'b0, pos_i} < on_lo;
  // A suppressed side forces its partner on; both short leaves both off
  assign hi_o     = !short_hi && (short_lo || hi_win);
  assign lo_o     = !short_lo && (short_hi || lo_win);
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
  import pwm3_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int NUM_LEGS = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CNT_W-1:0]          period_i,
  input  logic [NUM_LEGS*CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0]          dead_i,
  input  logic [CNT_W-1:0]          min_width_i,
  input  logic                      dbl_update_i,
  output logic                      sync_o,
  output logic [NUM_LEGS-1:0]       hi_o,
  output logic [NUM_LEGS-1:0]       lo_o
);
  localparam int DutyW = NUM_LEGS * CNT_W;

  logic [CNT_W-1:0]    per_s, dead_s, minw_s, pos;
  logic [DutyW-1:0]    duty_s;
  upd_mode_e           mode_s;
  logic                run, start, full_ld, half_ld;
  logic [NUM_LEGS-1:0] hi_d, lo_d;

  pwm3_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .per_i    (per_s),
    .mode_i   (mode_s),
    .pos_o    (pos),
    .run_o    (run),
    .start_o  (start),
    .full_ld_o(full_ld),
    .half_ld_o(half_ld)
  );

  pwm3_shadow #(.CNT_W(CNT_W), .NUM_LEGS(NUM_LEGS)) u_shd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .full_ld_i(full_ld),
    .half_ld_i(half_ld),
    .per_i    (period_i),
    .duty_i   (duty_i),
    .dead_i   (dead_i),
    .minw_i   (min_width_i),
    .mode_i   (dbl_update_i),
    .per_o    (per_s),
    .duty_o   (duty_s),
    .dead_o   (dead_s),
    .minw_o   (minw_s),
    .mode_o   (mode_s)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    pwm3_leg #(.CNT_W(CNT_W)) u_leg (
      .pos_i (pos),
      .per_i (per_s),
      .duty_i(duty_s[g*CNT_W +: CNT_W]),
      .dead_i(dead_s),
      .minw_i(minw_s),
      .hi_o  (hi_d[g]),
      .lo_o  (lo_d[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_o <= 1'b0;
      hi_o   <= '0;
      lo_o   <= '0;
    end else begin
      sync_o <= start;
      hi_o   <= run ? hi_d : '0;
      lo_o   <= run ? lo_d : '0;
    end
  end
endmodule

// File: rtl/pwm3_timer_chk.sv
module pwm3_timer_chk #(
  parameter int NUM_LEGS = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sync_o,
  input logic [NUM_LEGS-1:0] hi_o,
  input logic [NUM_LEGS-1:0] lo_o
);
  logic [NUM_LEGS-1:0] hi_prev_q, lo_prev_q, hi_seen_q, lo_seen_q;
  logic [NUM_LEGS-1:0] hi_rise, lo_fall;

  assign hi_rise = hi_o & ~hi_prev_q;
  assign lo_fall = ~lo_o & lo_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_prev_q <= '0;
      lo_prev_q <= '0;
      hi_seen_q <= '0;
      lo_seen_q <= '0;
    end else begin
      hi_prev_q <= hi_o;
      lo_prev_q <= lo_o;
      hi_seen_q <= sync_o ? hi_rise : (hi_seen_q | hi_rise);
      lo_seen_q <= sync_o ? lo_fall : (lo_seen_q | lo_fall);
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (hi_o == '0 && lo_o == '0 && !sync_o)
        else $error("outputs active during reset");
    end
  end

  assert_sync_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

  assert_hi_one_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_o |-> ((hi_rise & hi_seen_q) == '0));

  assert_lo_one_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_o |-> ((lo_fall & lo_seen_q) == '0));

  assert_no_overlap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_o & lo_o) == '0);
endmodule

bind pwm3_timer pwm3_timer_chk #(.NUM_LEGS(NUM_LEGS)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sync_o(sync_o),
  .hi_o  (hi_o),
  .lo_o  (lo_o)
);

// File: tb/pwm3_timer_tb_top.sv
module pwm3_timer_tb_top;
  localparam int W = 10;
  localparam int L = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic [W-1:0]   period_i, dead_i, min_width_i;
  logic [L*W-1:0] duty_i;
  logic           dbl_update_i;
  logic           sync_o;
  logic [L-1:0]   hi_o, lo_o;

  int n_chk = 0;
  int n_err = 0;
  int hc1[L], lc1[L], hc2[L], lc2[L], first_hi[L], last_lo[L];

  always #10 clk_i = ~clk_i;

  pwm3_timer #(.CNT_W(W), .NUM_LEGS(L)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .period_i    (period_i),
    .duty_i      (duty_i),
    .dead_i      (dead_i),
    .min_width_i (min_width_i),
    .dbl_update_i(dbl_update_i),
    .sync_o      (sync_o),
    .hi_o        (hi_o),
    .lo_o        (lo_o)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void exp_leg(input int p, d, dt, mw, output int eh, output int el);
    int oh, ol;
    bit sh, sl;
    oh = (d > dt) ? d - dt : 0;
    ol = (p > d + dt) ? p - d - dt : 0;
    sh = oh < mw;
    sl = ol < mw;
    eh = sh ? 0 : (sl ? p : (oh > p ? p : oh));
    el = sl ? 0 : (sh ? p : ol);
  endfunction

  task automatic set_cfg(input int p, da, db, dc, dt, mw, input bit md);
    period_i     = W'(p);
    duty_i       = {W'(dc), W'(db), W'(da)};
    dead_i       = W'(dt);
    min_width_i  = W'(mw);
    dbl_update_i = md;
  endtask

  task automatic wait_sync();
    do @(negedge clk_i); while (!sync_o);
  endtask

  // Starts in a sync cycle; ends in the next one
  task automatic run_period(input int p, input bit chg, input int na, nb, nc, ndt,
                            input bit nm);
    int extra = 0;
    for (int k = 0; k < L; k++) begin
      hc1[k] = 0; lc1[k] = 0; hc2[k] = 0; lc2[k] = 0;
      first_hi[k] = -1; last_lo[k] = -1;
    end
    for (int idx = 0; idx < 2 * p; idx++) begin
      if (idx > 0) @(negedge clk_i);
      if (idx > 0 && sync_o) extra++;
      for (int k = 0; k < L; k++) begin
        if (idx < p) begin
          if (hi_o[k]) begin
            hc1[k]++;
            if (first_hi[k] < 0) first_hi[k] = idx;
          end
          if (lo_o[k]) begin
            lc1[k]++;
            last_lo[k] = idx;
          end
        end else begin
          if (hi_o[k]) hc2[k]++;
          if (lo_o[k]) lc2[k]++;
        end
      end
      if (idx == 0 && chg) begin
        duty_i       = {W'(nc), W'(nb), W'(na)};
        dead_i       = W'(ndt);
        dbl_update_i = nm;
      end
    end
    @(negedge clk_i);
    chk_eq("R2 sync after 2P cycles", int'(sync_o), 1);
    chk_eq("R2 no sync inside period", extra, 0);
  endtask

  task automatic check_half(input string tag, input bit second, input int p,
                            input int da, db, dc, dt, mw);
    int d[L];
    int eh, el;
    d[0] = da; d[1] = db; d[2] = dc;
    for (int k = 0; k < L; k++) begin
      exp_leg(p, d[k], dt, mw, eh, el);
      chk_eq($sformatf("%s leg%0d half%0d hi", tag, k, second ? 2 : 1),
             second ? hc2[k] : hc1[k], eh);
      chk_eq($sformatf("%s leg%0d half%0d lo", tag, k, second ? 2 : 1),
             second ? lc2[k] : lc1[k], el);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b1;
    set_cfg(16, 6, 10, 3, 2, 0, 1'b0);
    #1 rst_ni = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      chk_eq("R1 hi in reset", int'(hi_o), 0);
      chk_eq("R1 lo in reset", int'(lo_o), 0);
      chk_eq("R1 sync in reset", int'(sync_o), 0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_eq("R1 sync first cycle", int'(sync_o), 0);
    chk_eq("R1 hi first cycle", int'(hi_o), 0);
    @(negedge clk_i);
    chk_eq("R1 sync second cycle", int'(sync_o), 1);
  endtask

  task automatic t_basic();
    run_period(16, 1'b0, 0, 0, 0, 0, 1'b0);
    check_half("R3/R4 basic", 1'b0, 16, 6, 10, 3, 2, 0);
    check_half("R3/R4 basic", 1'b1, 16, 6, 10, 3, 2, 0);
    chk_eq("R3 leg0 hi start", first_hi[0], 12);
    chk_eq("R3 leg1 hi start", first_hi[1], 8);
    chk_eq("R3 leg2 hi start", first_hi[2], 15);
    chk_eq("R4 leg0 lo end", last_lo[0], 7);
    chk_eq("R4 leg1 lo end", last_lo[1], 3);
    chk_eq("R4 leg2 lo end", last_lo[2], 10);
  endtask

  task automatic t_clamp();
    set_cfg(16, 1, 15, 8, 2, 0, 1'b0);
    wait_sync(); wait_sync();
    run_period(16, 1'b0, 0, 0, 0, 0, 1'b0);
    check_half("R3/R4 clamp", 1'b0, 16, 1, 15, 8, 2, 0);
    check_half("R3/R4 clamp", 1'b1, 16, 1, 15, 8, 2, 0);
  endtask

  task automatic t_suppress();
    set_cfg(200, 5, 100, 195, 3, 10, 1'b0);
    wait_sync(); wait_sync();
    run_period(200, 1'b0, 0, 0, 0, 0, 1'b0);
    check_half("R6/R7 suppress", 1'b0, 200, 5, 100, 195, 3, 10);
    check_half("R6/R7 suppress", 1'b1, 200, 5, 100, 195, 3, 10);
  endtask

  task automatic t_both_short();
    set_cfg(10, 5, 2, 5, 0, 8, 1'b0);
    wait_sync(); wait_sync();
    run_period(10, 1'b0, 0, 0, 0, 0, 1'b0);
    check_half("R8 both short", 1'b0, 10, 5, 2, 5, 0, 8);
    check_half("R8 both short", 1'b1, 10, 5, 2, 5, 0, 8);
  endtask

  task automatic t_update_modes();
    set_cfg(16, 6, 8, 8, 1, 0, 1'b0);
    wait_sync(); wait_sync();
    // single mode in force: mid-period changes wait for the next period
    run_period(16, 1'b1, 10, 8, 8, 1, 1'b1);
    check_half("R9 single", 1'b0, 16, 6, 8, 8, 1, 0);
    check_half("R9/R11 single", 1'b1, 16, 6, 8, 8, 1, 0);
    // double mode now in force: duty re-captured at midpoint, dead time not
    run_period(16, 1'b1, 4, 8, 8, 3, 1'b1);
    check_half("R11 new period", 1'b0, 16, 10, 8, 8, 1, 0);
    check_half("R10 midpoint", 1'b1, 16, 4, 8, 8, 1, 0);
    run_period(16, 1'b0, 0, 0, 0, 0, 1'b0);
    check_half("R10 dead at start", 1'b0, 16, 4, 8, 8, 3, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_clamp();
    t_suppress();
    t_both_short();
    t_update_modes();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule